// File: doc/BRIEF.md
# Page buffer with timed write commit

This block sits between a two-wire serial memory protocol engine and a byte-wide storage array. During a write transfer the engine reports the start of the transfer together with the target address, and then passes on each received data byte. The block keeps those bytes in a page-sized holding latch, one slot per byte of the page, and marks each slot it has filled. The slot pointer starts at the low address bits and wraps within the page. The high address bits select the page row and never change during a transfer.

When the engine reports a proper stop, the block opens a self-timed write window. The window lasts a parameterised number of system clocks, and `busy_o` is high for its whole length. In the last clock of the window the filled slots are copied into the array, so a partial page changes only the locations that were actually sent. While `busy_o` is high, every transfer event and every read request is ignored. A repeated start, a stop that arrives part way through a byte, or a high write-protect input at stop time all leave the array untouched and open no window. The engine signals the first two cases on the abort input.

Top module: `pgbuf_commit`

## Requirements
- R1: At commit only slots filled during the current transfer are written to the array; the other locations of the same page keep their previous contents (partial page).
- R2: An accepted transfer start clears every slot flag and loads the page row from address bits [ADDR_W-1:OFF_W] and the slot pointer from bits [OFF_W-1:0], where OFF_W = log2(PAGE_BYTES); slots filled by an earlier transfer that was not committed are never written.
- R3: Each accepted byte goes to the slot under the pointer, and the pointer then advances modulo PAGE_BYTES, so bytes beyond one page overwrite earlier slots of the same page and the last byte sent to a slot wins.
- R4: A stop during an open transfer with write-protect low and at least one filled slot raises `busy_o` from the next clock for exactly WCYC clocks; the array holds the new data from the clock in which `busy_o` falls.
- R5: While `busy_o` is high, transfer start, data bytes, stop, abort and read requests have no effect, and a stop seen inside the window does not extend it or open a second one.
- R6: With write-protect high at the stop, nothing in the array changes and `busy_o` stays low.
- R7: Abort closes the open transfer and discards its slots; a later stop without a new start opens no window and changes nothing.
- R8: A read request while not busy returns the array byte at `rd_addr_i` on `rd_data_o` one clock later; while busy, `rd_data_o` holds its value.
- R9: After reset `busy_o` is low and `rd_data_o` is zero.
- R10: A stop that ends a transfer with no bytes opens no write window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| open_i | input | 1 | Start of a write transfer (one-clock pulse) |
| open_addr_i | input | ADDR_W | Array address of the first byte of the transfer |
| byte_vld_i | input | 1 | A received data byte is present (one-clock pulse) |
| byte_dat_i | input | 8 | Received data byte |
| stop_i | input | 1 | Proper stop ending the transfer |
| abort_i | input | 1 | Repeated start or a stop part way through a byte |
| wp_i | input | 1 | Write protect, high blocks the whole array |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Registered read data |
| busy_o | output | 1 | Write window in progress |

## Verification
The hardest case to reach from the ports is a holding latch whose slots still carry flags and data that differ from the array when a new transfer begins. Only then does a failure to clear the flags become visible. The bench reaches this state by sending a full page that a high write-protect input blocks at the stop, which leaves the flags set. It then sends a one-byte transfer to the same page and reads the whole page back. A second case fills the write window with a read, a start, a byte, a stop and an abort. It then checks that the window length, the held read data and the array contents are all unchanged.

// File: rtl/pgc_pkg.sv
package pgc_pkg;
  localparam int DATA_W = 8;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/pgc_slots.sv
module pgc_slots
  import pgc_pkg::*;
#(
  parameter int PAGE_BYTES = 8,
  parameter int ROW_W      = 5,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         busy_i,
  input  logic                         wp_i,
  input  logic                         open_i,
  input  logic [ROW_W-1:0]             open_row_i,
  input  logic [OFF_W-1:0]             open_off_i,
  input  logic                         byte_vld_i,
  input  byte_t                        byte_dat_i,
  input  logic                         stop_i,
  input  logic                         abort_i,
  output logic                         go_o,
  output logic [ROW_W-1:0]             row_o,
  output logic [PAGE_BYTES-1:0]        vld_o,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0] dat_o
);

  logic                  act_q, act_d;
  logic [ROW_W-1:0]      row_q, row_d;
  logic [OFF_W-1:0]      off_q, off_d;
  logic [PAGE_BYTES-1:0] vld_q, vld_d;
  logic                  take, do_abort, do_open, do_stop, do_byte;

  always_comb begin
    take     = !busy_i;
    do_abort = take && abort_i;
    do_open  = take && !abort_i && open_i;
    do_stop  = take && !abort_i && !open_i && stop_i && act_q;
    do_byte  = take && !abort_i && !open_i && !stop_i && byte_vld_i && act_q;

    act_d = act_q;
    row_d = row_q;
    off_d = off_q;
    vld_d = vld_q;
    if (do_abort) begin
      act_d = 1'b0;
      vld_d = '0;
    end else if (do_open) begin
      act_d = 1'b1;
      row_d = open_row_i;
      off_d = open_off_i;
      vld_d = '0;
    end else if (do_stop) begin
      act_d = 1'b0;
    end else if (do_byte) begin
      vld_d[off_q] = 1'b1;
      off_d        = off_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      row_q <= '0;
      off_q <= '0;
      vld_q <= '0;
    end else begin
      act_q <= act_d;
      row_q <= row_d;
      off_q <= off_d;
      vld_q <= vld_d;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic  slot_we;
    byte_t cell_q;
    assign slot_we = do_byte && (off_q == OFF_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        cell_q <= byte_dat_i;
      end
    end
    assign dat_o[g] = cell_q;
  end

  assign go_o  = do_stop && !wp_i && (|vld_q);
  assign row_o = row_q;
  assign vld_o = vld_q;

  AST_FLAGS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (open_i && !abort_i && !busy_i) |=> (vld_q == '0)); // R2

  AST_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> ($stable(vld_q) && $stable(row_q) && $stable(off_q))); // R5

endmodule

// File: rtl/pgc_timer.sv
module pgc_timer #(
  parameter int WCYC   = 40,
  localparam int CW    = (WCYC > 1) ? $clog2(WCYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  output logic busy_o,
  output logic fire_o
);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  always_comb begin
    last   = busy_q && (cnt_q == '0);
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (!busy_q && go_i) begin
      busy_d = 1'b1;
      cnt_d  = CW'(WCYC - 1);
    end else if (busy_q) begin
      if (last) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign fire_o = last;

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CW'(WCYC - 1))); // R4

endmodule

// File: rtl/pgc_array.sv
module pgc_array
  import pgc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 8,
  localparam int OFF_W     = $clog2(PAGE_BYTES),
  localparam int ROW_W     = ADDR_W - OFF_W,
  localparam int DEPTH     = 1 << ADDR_W
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              fire_i,
  input  logic                              busy_i,
  input  logic [ROW_W-1:0]                  row_i,
  input  logic [PAGE_BYTES-1:0]             vld_i,
  input  logic [PAGE_BYTES-1:0][DATA_W-1:0] dat_i,
  input  logic                              rd_en_i,
  input  logic [ADDR_W-1:0]                 rd_addr_i,
  output byte_t                             rd_data_o
);

  byte_t mem [DEPTH];
  byte_t rd_q;
  logic  rd_take;

  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (fire_i && vld_i[i]) begin
        mem[{row_i, OFF_W'(i)}] <= dat_i[i];
      end
    end
  end

  assign rd_take = rd_en_i && !busy_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_take) begin
      rd_q <= mem[rd_addr_i];
    end
  end

  assign rd_data_o = rd_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(rd_data_o)); // R8

endmodule

// File: rtl/pgbuf_commit.sv
module pgbuf_commit
  import pgc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int WCYC       = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_i,
  input  logic [ADDR_W-1:0] open_addr_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_dat_i,
  input  logic              stop_i,
  input  logic              abort_i,
  input  logic              wp_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              busy_o
);

  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int ROW_W = ADDR_W - OFF_W;

  logic rst_m_q, rst_s_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  logic                              go;
  logic                              fire;
  logic [ROW_W-1:0]                  row;
  logic [PAGE_BYTES-1:0]             vld;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] dat;

  pgc_slots #(
    .PAGE_BYTES (PAGE_BYTES),
    .ROW_W      (ROW_W)
  ) slots_i (
    .clk        (clk),
    .rst_n      (rst_s_q),
    .busy_i     (busy_o),
    .wp_i       (wp_i),
    .open_i     (open_i),
    .open_row_i (open_addr_i[ADDR_W-1:OFF_W]),
    .open_off_i (open_addr_i[OFF_W-1:0]),
    .byte_vld_i (byte_vld_i),
    .byte_dat_i (byte_dat_i),
    .stop_i     (stop_i),
    .abort_i    (abort_i),
    .go_o       (go),
    .row_o      (row),
    .vld_o      (vld),
    .dat_o      (dat)
  );

  pgc_timer #(
    .WCYC (WCYC)
  ) timer_i (
    .clk    (clk),
    .rst_n  (rst_s_q),
    .go_i   (go),
    .busy_o (busy_o),
    .fire_o (fire)
  );

  pgc_array #(
    .ADDR_W     (ADDR_W),
    .PAGE_BYTES (PAGE_BYTES)
  ) array_i (
    .clk       (clk),
    .rst_n     (rst_s_q),
    .fire_i    (fire),
    .busy_i    (busy_o),
    .row_i     (row),
    .vld_i     (vld),
    .dat_i     (dat),
    .rd_en_i   (rd_en_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_s_q)
    $rose(busy_o) |-> $past(stop_i && !wp_i)); // R4

  AST_WP_BLOCK: assert property (@(posedge clk) disable iff (!rst_s_q)
    (stop_i && wp_i && !busy_o) |=> !busy_o); // R6

  AST_ABORT_DROP: assert property (@(posedge clk) disable iff (!rst_s_q)
    (abort_i && !busy_o) |=> !busy_o); // R7

endmodule

// File: tb/pgbuf_commit_tb_top.sv
module pgbuf_commit_tb_top;

  localparam int TB_WCYC = 40;
  localparam int NVEC    = 8;

  // entry: {addr[7:0], count[4:0], seed[7:0], wp}
  localparam logic [21:0] VEC [NVEC] = '{
    {8'h00, 5'd8,  8'h10, 1'b0},
    {8'h08, 5'd8,  8'h20, 1'b0},
    {8'hF8, 5'd8,  8'hC0, 1'b0},
    {8'h03, 5'd2,  8'hA0, 1'b0},
    {8'h0E, 5'd11, 8'h30, 1'b0},
    {8'h00, 5'd3,  8'h55, 1'b1},
    {8'hFB, 5'd5,  8'hE0, 1'b0},
    {8'h05, 5'd16, 8'h70, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       open_i = 1'b0;
  logic [7:0] open_addr_i = '0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_dat_i = '0;
  logic       stop_i = 1'b0;
  logic       abort_i = 1'b0;
  logic       wp_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [7:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic       busy_o;

  int tests = 0;
  int fails = 0;
  logic [7:0] mdl   [256];
  bit         known [256];

  always #5 clk = ~clk;

  pgbuf_commit #(.ADDR_W(8), .PAGE_BYTES(8), .WCYC(TB_WCYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .open_i(open_i), .open_addr_i(open_addr_i),
    .byte_vld_i(byte_vld_i), .byte_dat_i(byte_dat_i), .stop_i(stop_i),
    .abort_i(abort_i), .wp_i(wp_i), .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .busy_o(busy_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_open(input logic [7:0] a);
    open_i = 1'b1; open_addr_i = a;
    @(negedge clk);
    open_i = 1'b0;
  endtask

  task automatic do_byte(input logic [7:0] d);
    byte_vld_i = 1'b1; byte_dat_i = d;
    @(negedge clk);
    byte_vld_i = 1'b0;
  endtask

  task automatic do_stop(input logic w);
    stop_i = 1'b1; wp_i = w;
    @(negedge clk);
    stop_i = 1'b0; wp_i = 1'b0;
  endtask

  task automatic do_abort();
    abort_i = 1'b1;
    @(negedge clk);
    abort_i = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] d);
    rd_en_i = 1'b1; rd_addr_i = a;
    @(negedge clk);
    rd_en_i = 1'b0;
    d = rd_data_o;
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy_o && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_page(input string req, input logic [7:0] a);
    logic [7:0] d;
    for (int o = 0; o < 8; o++) begin
      logic [7:0] ad;
      ad = {a[7:3], 3'(o)};
      if (known[ad]) begin
        do_read(ad, d);
        chk(req, d, mdl[ad]);
      end
    end
  endtask

  task automatic run_txn(input string req, input logic [7:0] a, input int n,
                         input logic [7:0] seed, input logic w);
    int nb;
    do_open(a);
    for (int k = 0; k < n; k++) do_byte(seed + 8'(k));
    do_stop(w);
    count_busy(nb);
    chk(req, nb, (!w && n > 0) ? TB_WCYC : 0);
    if (!w) begin
      for (int k = 0; k < n; k++) begin
        logic [7:0] ad;
        ad = {a[7:3], 3'(a[2:0] + 3'(k))};
        mdl[ad]   = seed + 8'(k);
        known[ad] = 1'b1;
      end
    end
    check_page(req, a);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] d, v8;
    int nb;
    for (int i = 0; i < 256; i++) known[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: reset state
    chk("R9 busy", busy_o, 0);
    chk("R9 rd_data", rd_data_o, 0);

    // table walk: R1 R3 R4 R6
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] a, s;
      int n;
      logic w;
      string req;
      a = VEC[v][21:14];
      n = int'(VEC[v][13:9]);
      s = VEC[v][8:1];
      w = VEC[v][0];
      req = w ? "R6" : (n > 8) ? "R3" : (n < 8) ? "R1" : "R4";
      run_txn(req, a, n, s, w);
    end

    // R2: flags left set by a blocked transfer must not commit stale slots
    run_txn("R2 fill", 8'h10, 8, 8'h01, 1'b0);
    run_txn("R2 blocked", 8'h10, 8, 8'h81, 1'b1);
    run_txn("R2", 8'h12, 1, 8'h5A, 1'b0);

    // R7: abort discards, following stop does nothing
    run_txn("R7 fill", 8'h18, 8, 8'h40, 1'b0);
    do_open(8'h18);
    for (int k = 0; k < 8; k++) do_byte(8'hF0 + 8'(k));
    do_abort();
    do_stop(1'b0);
    chk("R7 busy", busy_o, 0);
    check_page("R7", 8'h18);

    // R10: empty transfer
    do_open(8'h20);
    do_stop(1'b0);
    chk("R10 busy", busy_o, 0);

    // R5 and R8: activity inside the write window
    do_read(8'h08, v8);
    chk("R8 read", v8, mdl[8'h08]);
    do_open(8'h00);
    do_byte(8'hEE);
    do_stop(1'b0);
    chk("R4 busy rise", busy_o, 1);
    do_read(8'h10, d);
    chk("R8 hold", d, v8);
    do_open(8'h08);
    do_byte(8'h99);
    do_stop(1'b0);
    do_abort();
    count_busy(nb);
    chk("R5 window", nb, TB_WCYC - 5);
    @(negedge clk);
    chk("R5 no rewindow", busy_o, 0);
    do_stop(1'b0);
    chk("R5 stale stop", busy_o, 0);
    mdl[8'h00] = 8'hEE;
    check_page("R5 page0", 8'h00);
    check_page("R5 page1", 8'h08);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule